// File: doc/BRIEF.md
# Machine Interrupt and Timer Controller

This block owns the interrupt pending and interrupt enable state of one hart and the machine timer compare register. Every cycle it compares a free-running 64-bit time value against the compare register. A match sets a sticky machine-timer pending bit. The block then ANDs the pending and enable vectors and gates the result by the current privilege level and the global interrupt-enable bit. From this it produces an interrupt request and a cause word for the trap logic.

Software reaches the state through a plain CSR port. The port has a write strobe, a 3-bit view selector, write data and a combinational read-data output. There are five views:

- machine pending
- machine enable
- supervisor pending
- supervisor enable
- timer compare

Each view has its own write mask. An inter-processor-interrupt strobe and a host-message-valid flag are the other two sources.

All pins are control or status signals. None carries a stream, so there is no valid/ready handshake and no back-pressure. The request and cause are combinational in the registered state and the current privilege inputs.

Top module: `irqc_top`

## Requirements
- R1: On a clock edge where `time_i` is greater than or equal to the compare register, machine-timer pending (bit 7) is set from the next cycle on. It then stays set while time falls back below the compare value, until it is cleared.
- R2: A write to the timer compare view (selector 4) clears machine-timer pending at that edge. This clear wins over a match in the same cycle.
- R3: Pending/enable bit positions are: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7. The selectors are 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable, 4 timer compare. After reset, all pending and enable bits read 0, the compare reads all ones, and no request is raised.
- R4: A write through the machine pending view changes only bits 1, 3 and 5.
- R5: A write through the machine enable view changes only bits 1, 3, 5 and 7.
- R6: The supervisor pending view reads bits 1 and 5 of pending and no other bit. A write through it changes only bit 1.
- R7: The supervisor enable view reads bits 1 and 5 of enable, and a write through it changes only those two bits.
- R8: `ipi_i` sets machine-software pending at the edge. It wins over a clearing write through the machine pending view in the same cycle.
- R9: Machine sources qualify when privilege (U=0, S=1, M=3) is below M, or is M with `gie_i` high. They are checked in this order: enabled machine-software pending (code 0), enabled machine-timer pending (code 1), `host_valid_i` (code 2, needs no enable bit).
- R10: Supervisor sources qualify when privilege is below S, or is S with `gie_i` high. They are checked after all machine sources: enabled supervisor-software pending (code 0), then enabled supervisor-timer pending (code 1).
- R11: With a request, `irq_cause_o` has bit XLEN-1 set and the source code in its low bits. Without one, the cause is zero.
- R12: Selectors 5 to 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | XLEN | Free-running real-time counter value |
| priv_i | input | 2 | Current privilege level (U=0, S=1, M=3) |
| gie_i | input | 1 | Global interrupt enable at the current privilege |
| host_valid_i | input | 1 | A nonzero host message is waiting |
| ipi_i | input | 1 | Inter-processor interrupt strobe |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | CSR view selector |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the selected view |
| irq_req_o | output | 1 | Interrupt request |
| irq_cause_o | output | XLEN | Cause word of the winning source |

## Verification
Directed writes of all-ones and all-zeros through each view show whether any write mask lets a foreign bit through. They also show whether a supervisor view leaks a machine bit on read. A time ramp that rises past the compare and falls back separates a sticky pending bit from a level comparison. A compare write while time is already past the new value shows whether the clear or the match wins. A long random run then varies privilege, global enable, host flag, IPI and CSR traffic together. This mixes many sources pending at once, so it tells a correct priority order and gating apart from swapped machine and supervisor checks or wrong privilege thresholds.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_W  = 8;
  localparam int CODE_W = 2;

  localparam int B_SSW = 1;
  localparam int B_MSW = 3;
  localparam int B_STM = 5;
  localparam int B_MTM = 7;

  localparam logic [2:0] SEL_MPEND = 3'd0;
  localparam logic [2:0] SEL_MEN   = 3'd1;
  localparam logic [2:0] SEL_SPEND = 3'd2;
  localparam logic [2:0] SEL_SEN   = 3'd3;
  localparam logic [2:0] SEL_TCMP  = 3'd4;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [CODE_W-1:0] CODE_SW   = 2'd0;
  localparam logic [CODE_W-1:0] CODE_TMR  = 2'd1;
  localparam logic [CODE_W-1:0] CODE_HOST = 2'd2;

  localparam logic [IRQ_W-1:0] MPEND_WMASK = (IRQ_W'(1) << B_SSW) | (IRQ_W'(1) << B_MSW) | (IRQ_W'(1) << B_STM);
  localparam logic [IRQ_W-1:0] MEN_WMASK   = MPEND_WMASK | (IRQ_W'(1) << B_MTM);
  localparam logic [IRQ_W-1:0] SPEND_WMASK = IRQ_W'(1) << B_SSW;
  localparam logic [IRQ_W-1:0] SUP_MASK    = (IRQ_W'(1) << B_SSW) | (IRQ_W'(1) << B_STM);
endpackage

// File: rtl/irqc_timer.sv
module irqc_timer #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] time_i,
  input  logic            cmp_we_i,
  input  logic [XLEN-1:0] cmp_wdata_i,
  output logic [XLEN-1:0] cmp_o,
  output logic            mtip_o
);
  logic [XLEN-1:0] cmp_q;
  logic            mtip_q;
  logic            hit;

  assign hit = (time_i >= cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      mtip_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
      mtip_q <= cmp_we_i ? 1'b0 : (mtip_q | hit);
    end
  end

  assign cmp_o  = cmp_q;
  assign mtip_o = mtip_q;

  AST_MATCH_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (hit && !cmp_we_i) |=> mtip_o); // R1
  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (mtip_o && !cmp_we_i) |=> mtip_o); // R1
  AST_CMP_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cmp_we_i |=> !mtip_o); // R2
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we_i,
  input  logic [2:0]       csr_sel_i,
  input  logic [IRQ_W-1:0] csr_wdata_i,
  input  logic             ipi_i,
  input  logic             mtip_i,
  output logic [IRQ_W-1:0] pend_o,
  output logic [IRQ_W-1:0] en_o
);
  logic [IRQ_W-1:0] pend_q, pend_d;
  logic [IRQ_W-1:0] en_q, en_d;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    if (csr_we_i) begin
      case (csr_sel_i)
        SEL_MPEND: pend_d = (pend_q & ~MPEND_WMASK) | (csr_wdata_i & MPEND_WMASK);
        SEL_SPEND: pend_d = (pend_q & ~SPEND_WMASK) | (csr_wdata_i & SPEND_WMASK);
        SEL_MEN:   en_d   = (en_q & ~MEN_WMASK) | (csr_wdata_i & MEN_WMASK);
        SEL_SEN:   en_d   = (en_q & ~SUP_MASK) | (csr_wdata_i & SUP_MASK);
        default:   ;
      endcase
    end
    if (ipi_i) pend_d[B_MSW] = 1'b1;
    pend_d[B_MTM] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    pend_o        = pend_q;
    pend_o[B_MTM] = mtip_i;
  end
  assign en_o = en_q;

  AST_IPI_SETS_MSW: assert property (@(posedge clk) disable iff (!rst_n) ipi_i |=> pend_o[B_MSW]); // R8
  AST_SPEND_WRITE_KEEPS_STM: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_sel_i == SEL_SPEND) |=> $stable(pend_o[B_STM])); // R6
  AST_SEN_WRITE_KEEPS_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_sel_i == SEL_SEN) |=> ($stable(en_o[B_MSW]) && $stable(en_o[B_MTM]))); // R7
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] en_i,
  input  logic [1:0]       priv_i,
  input  logic             gie_i,
  input  logic             host_valid_i,
  output logic             req_o,
  output logic [XLEN-1:0]  cause_o
);
  logic [IRQ_W-1:0]  act;
  logic              m_ok, s_ok;
  logic [CODE_W-1:0] code;
  logic              unused_bits;

  assign act         = pend_i & en_i;
  assign unused_bits = ^{act[0], act[2], act[4], act[6]};
  assign m_ok = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && gie_i);
  assign s_ok = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && gie_i);

  always_comb begin
    req_o = 1'b1;
    code  = CODE_SW;
    if (m_ok && act[B_MSW])      code = CODE_SW;
    else if (m_ok && act[B_MTM]) code = CODE_TMR;
    else if (m_ok && host_valid_i) code = CODE_HOST;
    else if (s_ok && act[B_SSW]) code = CODE_SW;
    else if (s_ok && act[B_STM]) code = CODE_TMR;
    else                         req_o = 1'b0;
  end

  assign cause_o = req_o ? ({1'b1, {(XLEN-1){1'b0}}} | XLEN'(code)) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] time_i,
  input  logic [1:0]      priv_i,
  input  logic            gie_i,
  input  logic            host_valid_i,
  input  logic            ipi_i,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            irq_req_o,
  output logic [XLEN-1:0] irq_cause_o
);
  localparam int PAD_W = XLEN - IRQ_W;

  logic [XLEN-1:0]  cmp;
  logic             mtip;
  logic             cmp_we;
  logic [IRQ_W-1:0] pend, en;

  assign cmp_we = csr_we_i && (csr_sel_i == SEL_TCMP);

  irqc_timer #(.XLEN(XLEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .time_i(time_i),
    .cmp_we_i(cmp_we), .cmp_wdata_i(csr_wdata_i),
    .cmp_o(cmp), .mtip_o(mtip)
  );

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
    .csr_wdata_i(csr_wdata_i[IRQ_W-1:0]), .ipi_i(ipi_i), .mtip_i(mtip),
    .pend_o(pend), .en_o(en)
  );

  irqc_arb #(.XLEN(XLEN)) u_arb (
    .pend_i(pend), .en_i(en), .priv_i(priv_i), .gie_i(gie_i),
    .host_valid_i(host_valid_i), .req_o(irq_req_o), .cause_o(irq_cause_o)
  );

  always_comb begin
    case (csr_sel_i)
      SEL_MPEND: csr_rdata_o = {{PAD_W{1'b0}}, pend};
      SEL_MEN:   csr_rdata_o = {{PAD_W{1'b0}}, en};
      SEL_SPEND: csr_rdata_o = {{PAD_W{1'b0}}, pend & SUP_MASK};
      SEL_SEN:   csr_rdata_o = {{PAD_W{1'b0}}, en & SUP_MASK};
      SEL_TCMP:  csr_rdata_o = cmp;
      default:   csr_rdata_o = '0;
    endcase
  end

  AST_CAUSE_MSB_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) irq_req_o |-> irq_cause_o[XLEN-1]); // R11
  AST_CAUSE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq_req_o |-> (irq_cause_o == '0)); // R11
  AST_HOST_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n) (host_valid_i && priv_i == PRIV_U) |-> irq_req_o); // R9
  AST_MACHINE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_M && !gie_i) |-> !irq_req_o); // R10
  AST_MPEND_NO_MTM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_sel_i == SEL_MPEND && !pend[B_MTM]) |=> !pend[B_MTM] || $past(time_i >= cmp)); // R4
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/100ps
module test_irqc_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [XLEN-1:0] time_v;
  logic [1:0]      priv;
  logic            gie, host, ipi, we;
  logic [2:0]      sel;
  logic [XLEN-1:0] wd;
  logic [XLEN-1:0] rdata, cause;
  logic            req;

  always #2 clk = ~clk;

  irqc_top #(.XLEN(XLEN)) i_irqc_top (
    .clk(clk), .rst_n(rst_n), .time_i(time_v), .priv_i(priv), .gie_i(gie),
    .host_valid_i(host), .ipi_i(ipi), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wd), .csr_rdata_o(rdata), .irq_req_o(req), .irq_cause_o(cause)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R3";
  logic [7:0]      m_pend, m_en;
  logic [XLEN-1:0] m_cmp;

  task automatic expect_val(input string t, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic model_check();
    logic [7:0] a;
    bit mok, sok, r;
    int code;
    logic [XLEN-1:0] ecause, erd;
    a = m_pend & m_en;
    mok = (priv < 2'd3) || (priv == 2'd3 && gie);
    sok = (priv < 2'd1) || (priv == 2'd1 && gie);
    r = 1; code = 0;
    if (mok && a[3]) code = 0;
    else if (mok && a[7]) code = 1;
    else if (mok && host) code = 2;
    else if (sok && a[1]) code = 0;
    else if (sok && a[5]) code = 1;
    else r = 0;
    ecause = r ? ((64'd1 << 63) | 64'(code)) : 64'd0;
    case (sel)
      3'd0: erd = {56'd0, m_pend};
      3'd1: erd = {56'd0, m_en};
      3'd2: erd = {56'd0, m_pend & 8'h22};
      3'd3: erd = {56'd0, m_en & 8'h22};
      3'd4: erd = m_cmp;
      default: erd = '0;
    endcase
    expect_val({tag, " req"}, {63'd0, req}, {63'd0, r});
    expect_val({tag, " cause"}, cause, ecause);
    expect_val({tag, " rdata"}, rdata, erd);
  endtask

  task automatic model_update();
    bit hit;
    hit = (time_v >= m_cmp);
    if (we) begin
      case (sel)
        3'd0: begin m_pend[1] = wd[1]; m_pend[3] = wd[3]; m_pend[5] = wd[5]; end
        3'd1: begin m_en[1] = wd[1]; m_en[3] = wd[3]; m_en[5] = wd[5]; m_en[7] = wd[7]; end
        3'd2: m_pend[1] = wd[1];
        3'd3: begin m_en[1] = wd[1]; m_en[5] = wd[5]; end
        3'd4: m_cmp = wd;
        default: ;
      endcase
    end
    if (ipi) m_pend[3] = 1'b1;
    if (we && sel == 3'd4) m_pend[7] = 1'b0;
    else if (hit) m_pend[7] = 1'b1;
  endtask

  task automatic tick();
    #0.5;
    model_check();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic csr(input bit w, input logic [2:0] s, input logic [XLEN-1:0] d, input bit p);
    we = w; sel = s; wd = d; ipi = p;
    tick();
    we = 0; ipi = 0;
  endtask

  task automatic peek(input string t, input logic [2:0] s, input logic [XLEN-1:0] exp);
    sel = s;
    #0.5;
    expect_val(t, rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; time_v = '0; priv = 2'd3; gie = 0; host = 0; ipi = 0; we = 0; sel = 0; wd = '0;
    m_pend = '0; m_en = '0; m_cmp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset values
    peek("R3 mpend", 3'd0, 64'h0);
    peek("R3 men", 3'd1, 64'h0);
    peek("R3 spend", 3'd2, 64'h0);
    peek("R3 sen", 3'd3, 64'h0);
    peek("R3 tcmp", 3'd4, '1);
    expect_val("R3 req", {63'd0, req}, 64'd0);
    @(negedge clk);

    tag = "R4"; csr(1, 3'd0, '1, 0); peek("R4 mask", 3'd0, 64'h2A);
    tag = "R5"; csr(1, 3'd1, '1, 0); peek("R5 mask", 3'd1, 64'hAA);
    tag = "R6"; csr(1, 3'd0, '0, 0); csr(1, 3'd2, '1, 0); peek("R6 ssw only", 3'd2, 64'h02);
    csr(1, 3'd0, 64'h20, 0); csr(1, 3'd2, '0, 0); peek("R6 stm kept", 3'd2, 64'h20);
    peek("R6 machine hidden", 3'd0, 64'h20);
    tag = "R7"; csr(1, 3'd3, '0, 0); peek("R7 clear", 3'd1, 64'h88);
    csr(1, 3'd3, '1, 0); peek("R7 set", 3'd3, 64'h22);
    tag = "R8"; csr(1, 3'd0, '0, 1); peek("R8 ipi wins", 3'd0, 64'h08);
    csr(1, 3'd0, '0, 0);

    tag = "R1"; csr(1, 3'd4, 64'd100, 0);
    time_v = 64'd50; csr(0, 3'd0, '0, 0); peek("R1 below", 3'd0, 64'h00);
    time_v = 64'd100; csr(0, 3'd0, '0, 0); peek("R1 equal sets", 3'd0, 64'h80);
    time_v = 64'd10; csr(0, 3'd0, '0, 0); peek("R1 sticky", 3'd0, 64'h80);
    tag = "R2"; time_v = 64'd300; csr(1, 3'd4, 64'd200, 0); peek("R2 clear wins", 3'd0, 64'h00);
    csr(0, 3'd0, '0, 0); peek("R2 rematch", 3'd0, 64'h80);

    tag = "R11"; priv = 2'd3; gie = 1; csr(1, 3'd0, '1, 0);
    #0.5; expect_val("R11 cause sw", cause, 64'h8000_0000_0000_0000);
    @(negedge clk);
    tag = "R10"; csr(1, 3'd0, 64'h02, 0); priv = 2'd1; time_v = 0; csr(1, 3'd4, '1, 0);
    #0.5; expect_val("R10 ssw from S", cause, 64'h8000_0000_0000_0000);
    @(negedge clk);
    gie = 0; #0.5; expect_val("R10 S masked", {63'd0, req}, 64'd0);
    @(negedge clk);

    tag = "R12"; csr(1, 3'd5, '1, 0); csr(1, 3'd7, '1, 0);
    peek("R12 read 6", 3'd6, 64'h0); peek("R12 pend kept", 3'd0, 64'h02);
    peek("R12 en kept", 3'd1, 64'hAA);
    @(negedge clk);

    tag = "R9 R10 R11";
    for (int i = 0; i < 3000; i++) begin
      priv   = 2'($urandom_range(0, 3));
      gie    = 1'($urandom);
      host   = ($urandom_range(0, 5) == 0);
      ipi    = ($urandom_range(0, 7) == 0);
      we     = ($urandom_range(0, 2) == 0);
      sel    = 3'($urandom_range(0, 7));
      wd     = {32'($urandom), 32'($urandom)};
      if (sel == 3'd4) wd = 64'($urandom_range(0, 1000));
      time_v = 64'($urandom_range(0, 1000));
      tick();
    end
    we = 0; ipi = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule